// File: doc/BRIEF.md
# Frame-Paced Pixel Dump Reader

This block lets a host walk through a stored sensor image one pixel at a time, using one byte-wide register. Every host access to the register, read or write, arms a single capture. The imaging pipeline signals the end of each frame with a one-cycle pulse. The first such pulse after arming makes the block fetch the pixel at its current pointer from the pixel memory, using a request/acknowledge exchange. The captured 6-bit value is held until the host reads it. Because only one pixel is taken per frame, pulling a whole 324-pixel image takes at least 324 frames.

Each read returns a status byte. Bit 7 is a start-of-frame flag, set when the returned pixel is pixel 1. Bit 6 is a data-valid flag. Bits 5:0 carry the pixel value. A read that finds no completed capture returns 0x00 and leaves the pointer where it is. A valid read moves the pointer on by one and wraps from 324 back to 1. A write of any value puts the pointer back to pixel 1 and discards any held capture.

Control is a four-state machine:
- `S_IDLE`: nothing is armed.
- `S_ARMED`: waiting for a frame pulse.
- `S_FETCH`: the memory request is outstanding.
- `S_HELD`: a captured value is waiting to be read.

Its transitions are:
- Arm: `S_IDLE` to `S_ARMED`, on any access.
- Frame: `S_ARMED` to `S_FETCH`, on a frame pulse.
- Latch: `S_FETCH` to `S_HELD`, on acknowledge.
- Consume: `S_HELD` to `S_ARMED`, on a read.
- Rearm: any state to `S_ARMED`, on a write.

Top module: `pix_dump_reader`

## Requirements
- R1: After reset, `rd_data` is 0x00, `pix_req` is low, the pointer is at pixel 1 and no capture is armed.
- R2: The byte of a valid read is {start-of-frame in bit 7, data-valid = 1 in bit 6, pixel value in bits 5:0}. It appears on `rd_data` in the cycle after the read strobe.
- R3: A write resets the pointer to pixel 1, discards any held capture and arms a new one. The next valid read returns pixel 1 with start-of-frame set.
- R4: Each valid read advances the pointer by one. Pixels 2 to 324 are returned with start-of-frame clear.
- R5: In the cycle after a frame pulse arrives while armed, `pix_req` rises with `pix_idx` equal to the pointer. Both are held until `pix_ack`.
- R6: At most one pixel is captured per frame. A frame pulse while idle or while a capture is held raises no request.
- R7: A read made before a capture has completed returns 0x00 and does not advance the pointer. If nothing was armed, it arms a capture.
- R8: After pixel 324, the pointer wraps to 1. The 325th valid read after a write returns pixel 1 with start-of-frame set.
- R9: A held value keeps the pixel value present at acknowledge, whatever later frames or memory contents do, until it is read.
- R10: A write has priority over a read in the same cycle. `rd_data` keeps its previous value, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle register read strobe |
| wr_stb | input | 1 | One-cycle register write strobe (data ignored) |
| frame_done | input | 1 | One-cycle end-of-frame pulse from the imaging pipeline |
| pix_req | output | 1 | Pixel fetch request to the pixel memory |
| pix_idx | output | 9 | Pixel number requested, 1 to 324 |
| pix_ack | input | 1 | Pixel memory response valid |
| pix_data | input | 6 | Pixel value returned with `pix_ack` |
| rd_data | output | 8 | Status byte of the last read |

## Verification
The block is exercised with several access patterns:
- Reads interleaved with frame pulses. These separate valid reads from reads made before a capture has completed.
- Repeated reads with no frame in between. These show that the pointer only moves on valid data.
- A write in the middle of a run. This shows the return to pixel 1.
- A full 325-read sweep. This exposes off-by-one errors at the wrap.

The pixel memory model can also be made to withhold its acknowledge, or to change its contents after a capture. This tells a request that is held apart from one that is dropped, and a latched value apart from one that follows the memory. Simultaneous read and write strobes check the priority rule.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_FETCH = 2'd2,
        S_HELD  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/pdr_ptr.sv
module pdr_ptr #(
    parameter int unsigned COUNT = 324,
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr,
    output logic             at_first
);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= FIRST;
        else if (clear)  ptr <= FIRST;
        else if (step)   ptr <= (ptr == LAST) ? FIRST : ptr + FIRST;
    end

    assign at_first = (ptr == FIRST);

    // R8: pointer stays inside 1..COUNT
    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= FIRST) && (ptr <= LAST));
    // R8: last pixel followed by a step wraps to the first
    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && ptr == LAST) |=> (ptr == FIRST));
    // R3: a clear always lands on pixel 1
    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == FIRST));
    // R7: no step and no clear leaves the pointer alone
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/pdr_fsm.sv
module pdr_fsm
    import pdr_pkg::*;
#(
    parameter int unsigned PIX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             frame_done,
    input  logic             pix_ack,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pix_req,
    output logic             held,
    output logic             consume,
    output logic [PIX_W-1:0] cap_val
);
    cap_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        pix_req  = 1'b0;
        held     = 1'b0;
        consume  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (rd_stb || wr_stb) state_nx = S_ARMED;            // arm
            end
            S_ARMED: begin
                if (wr_stb)          state_nx = S_ARMED;             // rearm
                else if (frame_done) state_nx = S_FETCH;             // frame
            end
            S_FETCH: begin
                pix_req = 1'b1;
                if (wr_stb)       state_nx = S_ARMED;                // rearm
                else if (pix_ack) state_nx = S_HELD;                 // latch
            end
            S_HELD: begin
                held = 1'b1;
                if (wr_stb)      state_nx = S_ARMED;                 // rearm
                else if (rd_stb) begin
                    state_nx = S_ARMED;                              // consume
                    consume  = 1'b1;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // captured pixel
    always_ff @(posedge clk) begin
        if (!rst_n)                                         cap_val <= '0;
        else if (state == S_FETCH && pix_ack && !wr_stb)    cap_val <= pix_data;
    end

    // R5: a frame pulse while armed raises the request next cycle
    assert_req_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && frame_done && !wr_stb) |=> pix_req);
    // R5: an unanswered request stays up
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_ack && !wr_stb) |=> pix_req);
    // R6: no request while a capture is held
    assert_no_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HELD && !rd_stb && !wr_stb) |=> !pix_req);
    // R9: held value does not move until consumed or discarded
    assert_cap_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HELD) |=> $stable(cap_val));
endmodule

// File: rtl/pdr_fmt.sv
module pdr_fmt #(
    parameter int unsigned PIX_W  = 6,
    parameter int unsigned BYTE_W = PIX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              held,
    input  logic              at_first,
    input  logic [PIX_W-1:0]  cap_val,
    output logic [BYTE_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb && !wr_stb)
            rd_data <= held ? {at_first, 1'b1, cap_val} : '0;
    end

    // R7: a read without a completed capture yields an all-zero byte
    assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !held) |=> (rd_data == '0));
    // R10: a write never changes the returned byte
    assert_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> $stable(rd_data));
endmodule

// File: rtl/pix_dump_reader.sv
module pix_dump_reader #(
    parameter int unsigned PIX_COUNT = 324,
    parameter int unsigned PIX_W     = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_stb,
    input  logic                             wr_stb,
    input  logic                             frame_done,
    output logic                             pix_req,
    output logic [$clog2(PIX_COUNT+1)-1:0]   pix_idx,
    input  logic                             pix_ack,
    input  logic [PIX_W-1:0]                 pix_data,
    output logic [PIX_W+1:0]                 rd_data
);
    localparam int unsigned IDX_W  = $clog2(PIX_COUNT + 1);
    localparam int unsigned BYTE_W = PIX_W + 2;

    logic             held;
    logic             consume;
    logic             at_first;
    logic [PIX_W-1:0] cap_val;

    pdr_fsm #(.PIX_W(PIX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .frame_done (frame_done),
        .pix_ack    (pix_ack),
        .pix_data   (pix_data),
        .pix_req    (pix_req),
        .held       (held),
        .consume    (consume),
        .cap_val    (cap_val)
    );

    pdr_ptr #(.COUNT(PIX_COUNT), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wr_stb),
        .step     (consume),
        .ptr      (pix_idx),
        .at_first (at_first)
    );

    pdr_fmt #(.PIX_W(PIX_W), .BYTE_W(BYTE_W)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .held     (held),
        .at_first (at_first),
        .cap_val  (cap_val),
        .rd_data  (rd_data)
    );

    // R5: request index is held steady while waiting for acknowledge
    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_ack && !wr_stb) |=> $stable(pix_idx));
endmodule

// File: tb/sim_pix_dump_reader.sv
module sim_pix_dump_reader;
    logic       clk = 1'b0;
    logic       rst_n, rd_stb, wr_stb, frame_done, pix_ack;
    logic [5:0] pix_data;
    logic       pix_req;
    logic [8:0] pix_idx;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int salt   = 3;
    bit ack_en = 1'b1;

    always #5 clk = ~clk;

    pix_dump_reader u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .frame_done(frame_done), .pix_req(pix_req), .pix_idx(pix_idx),
        .pix_ack(pix_ack), .pix_data(pix_data), .rd_data(rd_data)
    );

    function automatic logic [5:0] pix_of(input int idx);
        return 6'((idx * 5 + salt) % 64);
    endfunction

    function automatic logic [7:0] vbyte(input bit sof, input int idx);
        return {sof, 1'b1, pix_of(idx)};
    endfunction

    // pixel memory model: answers one cycle after a request
    initial begin
        pix_ack = 1'b0; pix_data = '0;
        forever begin
            @(negedge clk);
            if (ack_en && pix_req && !pix_ack) begin
                pix_ack  = 1'b1;
                pix_data = pix_of(int'(pix_idx));
            end else begin
                pix_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_frame();
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic do_read();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic do_write();
        wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
    endtask

    typedef struct packed {
        logic       op;     // 0 read, 1 write
        logic       frame;  // give a frame before the access
        logic       vld;
        logic       sof;
        logic [8:0] idx;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 9'd0},   // R7 read while idle
        '{1'b0, 1'b1, 1'b1, 1'b1, 9'd1},   // R2 first pixel
        '{1'b0, 1'b0, 1'b0, 1'b0, 9'd0},   // R7 read with no frame
        '{1'b0, 1'b1, 1'b1, 1'b0, 9'd2},   // R4 pointer not moved by R7 read
        '{1'b0, 1'b1, 1'b1, 1'b0, 9'd3},   // R4
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd0},   // R3 write
        '{1'b0, 1'b1, 1'b1, 1'b1, 9'd1},   // R3 back at pixel 1
        '{1'b0, 1'b1, 1'b1, 1'b0, 9'd2},   // R4
        '{1'b0, 1'b1, 1'b1, 1'b0, 9'd3}    // R4
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        rst_n = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; frame_done = 1'b0;
        tick(3);
        chk("R1 rd_data", {1'b0, rd_data}, 9'h000);
        chk("R1 pix_req", {8'h00, pix_req}, 9'h000);
        rst_n = 1'b1;
        tick(1);

        // R6: frame pulse while idle is ignored
        do_frame();
        chk("R6 idle frame", {8'h00, pix_req}, 9'h000);
        tick(2);

        foreach (TBL[i]) begin
            if (TBL[i].frame) begin do_frame(); tick(2); end
            if (TBL[i].op) do_write();
            else begin
                do_read();
                chk($sformatf("R2/R4/R7 vector %0d", i), {1'b0, rd_data},
                    {1'b0, TBL[i].vld ? vbyte(TBL[i].sof, int'(TBL[i].idx)) : 8'h00});
            end
        end

        // R5: request raised after frame and held without acknowledge (pointer at 4)
        ack_en = 1'b0;
        do_frame();
        chk("R5 req raised", {8'h00, pix_req}, 9'h001);
        chk("R5 req index", pix_idx, 9'd4);
        tick(3);
        chk("R5 req held", {8'h00, pix_req}, 9'h001);
        chk("R5 index held", pix_idx, 9'd4);
        ack_en = 1'b1;
        tick(3);

        // R9: memory changes and more frames after capture do not alter it
        keep  = vbyte(1'b0, 4);
        salt  = 40;
        for (int k = 0; k < 3; k++) begin
            do_frame();
            chk("R6 held frame", {8'h00, pix_req}, 9'h000);
            tick(1);
        end
        do_read();
        chk("R9 held value", {1'b0, rd_data}, {1'b0, keep});

        // R10: simultaneous read and write, write wins
        do_frame(); tick(2);
        rd_stb = 1'b1; wr_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R10 rd_data kept", {1'b0, rd_data}, {1'b0, keep});
        do_frame(); tick(2);
        do_read();
        chk("R10/R3 pixel 1 after write", {1'b0, rd_data}, {1'b0, vbyte(1'b1, 1)});

        // R8: full sweep plus wrap
        do_write();
        for (int p = 1; p <= 325; p++) begin
            int e;
            e = (p == 325) ? 1 : p;
            do_frame(); tick(2);
            do_read();
            chk($sformatf("R8/R4 sweep read %0d", p), {1'b0, rd_data},
                {1'b0, vbyte(e == 1, e)});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule